// File: doc/BRIEF.md
# Acquisition Sample FIFO Controller

This block sits between an analog converter and a host bus. It turns pacer ticks into start-conversion pulses and stores each finished sample in a sample FIFO. It also keeps three host-visible flags: an interrupt request, a trigger-seen indication and an overrun indication. A control register chooses the interrupt condition, the automatic flush at half-full, pre-trigger behaviour, the streaming transfer path, trigger use and the pacer source. A separate clear register empties the FIFO.

Conversions can run freely on every pacer tick. They can also be held until a rising edge on the external trigger, which then starts a block that ends at the total-count terminal count. In pre-trigger mode, conversions run the whole time and the trigger edge only marks its moment through the trigger-seen flag. Trigger edges count only when the internal pacer drives the conversions.

Top module: `acq_fifo_ctrl`

## Requirements
- R1: One write of `ctl_wdata` loads the whole control register. The bit layout is: [1:0] interrupt select, [2] auto-flush, [3] pre-trigger enable, [4] streaming enable, [5] trigger enable, [6] internal pacer (1) or external pacing (0). After reset all bits are 0.
- R2: Samples leave the FIFO in the order they were written. `rd_data` always shows the oldest entry. `rd_en` removes that entry, and `fifo_count` gives the number of entries held, up to DEPTH (1024).
- R3: With interrupt select 00, every `conv_done` sets `irq` in the following cycle.
- R4: With interrupt select 01, `irq` is never set.
- R5: With interrupt select 10 or 11, `irq` is set by a `tc_pulse`, or by a write that brings the FIFO count to exactly DEPTH/2 (512).
- R6: Once set, `irq` stays 1 until `irq_ack` is pulsed. An acknowledge in the same cycle as a new set condition leaves `irq` at 1.
- R7: With auto-flush on, the FIFO empties one cycle after its count reaches DEPTH/2. The half-full interrupt of R5 still fires.
- R8: A conversion that arrives while the FIFO is full is discarded. The count and the stored contents stay as they were.
- R9: `overrun` is set by the first `conv_done` that follows a `stream_err` seen while streaming is enabled. It is also set by a `conv_done` that arrives while the FIFO is full. A `stream_err` seen while streaming is disabled has no effect.
- R10: `overrun` is cleared when a control write has the streaming enable bit at 0, or when a clear write carries the value 0. A clear write with a non-zero value changes nothing.
- R11: A clear write of 0 empties the FIFO in one cycle. A sample offered in the same cycle is dropped.
- R12: When the trigger enable and the internal pacer bit are both 1 and pre-trigger is 0, pacer ticks start no conversion until a rising edge of `ext_trig` has been seen. After that edge each tick gives a one-cycle `start_conv` until a `tc_pulse` ends the block. One edge is accepted per low-to-high transition.
- R13: With external pacing, every pacer tick produces `start_conv` and trigger edges are ignored, including for `trig_seen`.
- R14: In pre-trigger mode (pre-trigger, trigger enable and internal pacer all 1), every tick produces `start_conv`. `trig_seen` rises after a trigger edge and is cleared by a clear write of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control register value |
| clr_we | input | 1 | Clear register write strobe |
| clr_wdata | input | 8 | Clear register value; 0 clears |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| conv_done | input | 1 | Conversion finished, data valid |
| conv_data | input | 12 | Converted sample |
| pacer_tick | input | 1 | Pacer pulse |
| tc_pulse | input | 1 | Total counter terminal count |
| ext_trig | input | 1 | Asynchronous external trigger, active high |
| stream_err | input | 1 | Streaming handshake failure |
| rd_en | input | 1 | Pop the oldest sample |
| rd_data | output | 12 | Oldest sample |
| fifo_count | output | 11 | Entries held |
| fifo_empty | output | 1 | FIFO holds nothing |
| irq | output | 1 | Interrupt request flag |
| trig_seen | output | 1 | Trigger has occurred (pre-trigger mode) |
| overrun | output | 1 | Overrun flag |
| start_conv | output | 1 | Start-conversion pulse |

## Verification
A corrupted pointer or count shows up on the next pop as a `rd_data` that does not match the scoreboard, and at once as a `fifo_count` off from the bench's own tally. A wrong interrupt or overrun latch shows in the cycle after the causing conversion, tick or strobe, because both flags are single registers that drive the ports directly. A wrong armed state in the trigger path is caught at the next pacer tick, where `start_conv` appears or is missing.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int CTRL_W = 7;

    typedef enum logic [1:0] {
        IRQ_ON_CONV  = 2'b00,
        IRQ_OFF      = 2'b01,
        IRQ_ON_BLK_A = 2'b10,
        IRQ_ON_BLK_B = 2'b11
    } irq_sel_e;

    // Packed MSB first: int_pacer is bit 6, irq_sel is bits 1:0.
    typedef struct packed {
        logic     int_pacer;
        logic     trig_en;
        logic     stream_en;
        logic     pretrig_en;
        logic     auto_flush;
        irq_sel_e irq_sel;
    } ctrl_t;

endpackage

// File: rtl/acq_trig_sync.sv
module acq_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = async_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.prev;
endmodule

// File: rtl/acq_sample_fifo.sv
module acq_sample_fifo #(
    parameter int DW    = 12,
    parameter int DEPTH = 1024
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [DW-1:0]                wr_data,
    input  logic                         rd_en,
    input  logic                         flush,
    output logic [DW-1:0]                rd_data,
    output logic [$clog2(DEPTH):0]       count,
    output logic                         full,
    output logic                         empty,
    output logic                         half_hit,
    output logic                         wr_drop
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = AW + 1;
    localparam int HALF = DEPTH / 2;

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic wr_ok, rd_ok;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign wr_ok = wr_en & ~full & ~flush;
    assign rd_ok = rd_en & ~empty & ~flush;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (wr_ok) st_d.wr_ptr = st_q.wr_ptr + 1'b1;
            if (rd_ok) st_d.rd_ptr = st_q.rd_ptr + 1'b1;
            st_d.cnt = st_q.cnt + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[st_q.wr_ptr] <= wr_data;
    end

    assign rd_data  = mem[st_q.rd_ptr];
    assign count    = st_q.cnt;
    assign half_hit = wr_ok & ~rd_ok & (st_q.cnt == CW'(HALF - 1));
    assign wr_drop  = wr_en & full & ~flush;
endmodule

// File: rtl/acq_seq.sv
module acq_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic int_pacer,
    input  logic trig_en,
    input  logic pretrig_en,
    input  logic pacer_tick,
    input  logic trig_rise,
    input  logic tc_pulse,
    input  logic clr_fire,
    output logic start_conv,
    output logic trig_seen
);
    typedef struct packed {
        logic armed;
        logic start;
        logic seen;
    } seq_t;

    seq_t st_d, st_q;
    logic gated, accept, run;

    assign gated  = trig_en & int_pacer;
    assign accept = trig_rise & gated;
    assign run    = ~gated | pretrig_en | st_q.armed;

    always_comb begin
        st_d       = st_q;
        st_d.start = pacer_tick & run;
        if (accept)        st_d.armed = 1'b1;
        else if (tc_pulse) st_d.armed = 1'b0;
        if (clr_fire)                 st_d.seen = 1'b0;
        else if (accept & pretrig_en) st_d.seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_conv = st_q.start;
    assign trig_seen  = st_q.seen;
endmodule

// File: rtl/acq_fifo_ctrl.sv
module acq_fifo_ctrl #(
    parameter int DW    = 12,
    parameter int DEPTH = 1024,
    parameter int CLR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_we,
    input  logic [acq_pkg::CTRL_W-1:0] ctl_wdata,
    input  logic                     clr_we,
    input  logic [CLR_W-1:0]         clr_wdata,
    input  logic                     irq_ack,
    input  logic                     conv_done,
    input  logic [DW-1:0]            conv_data,
    input  logic                     pacer_tick,
    input  logic                     tc_pulse,
    input  logic                     ext_trig,
    input  logic                     stream_err,
    input  logic                     rd_en,
    output logic [DW-1:0]            rd_data,
    output logic [$clog2(DEPTH):0]   fifo_count,
    output logic                     fifo_empty,
    output logic                     irq,
    output logic                     trig_seen,
    output logic                     overrun,
    output logic                     start_conv
);
    import acq_pkg::*;

    localparam int CW = $clog2(DEPTH) + 1;

    typedef struct packed {
        ctrl_t ctrl;
        logic  irq;
        logic  ovr;
        logic  fail_pend;
        logic  af_pend;
    } top_t;

    top_t st_d, st_q;
    ctrl_t wr_ctrl;
    logic clr_fire, flush, trig_rise;
    logic fifo_full, half_hit, wr_drop;
    logic irq_set, ovr_clr, fail_evt;

    assign wr_ctrl  = ctrl_t'(ctl_wdata);
    assign clr_fire = clr_we & (clr_wdata == '0);
    assign flush    = clr_fire | st_q.af_pend;

    acq_trig_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_trig),
        .rise     (trig_rise)
    );

    acq_sample_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (conv_done),
        .wr_data  (conv_data),
        .rd_en    (rd_en),
        .flush    (flush),
        .rd_data  (rd_data),
        .count    (fifo_count),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .half_hit (half_hit),
        .wr_drop  (wr_drop)
    );

    acq_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_pacer  (st_q.ctrl.int_pacer),
        .trig_en    (st_q.ctrl.trig_en),
        .pretrig_en (st_q.ctrl.pretrig_en),
        .pacer_tick (pacer_tick),
        .trig_rise  (trig_rise),
        .tc_pulse   (tc_pulse),
        .clr_fire   (clr_fire),
        .start_conv (start_conv),
        .trig_seen  (trig_seen)
    );

    always_comb begin
        irq_set  = ((st_q.ctrl.irq_sel == IRQ_ON_CONV) & conv_done)
                 | (st_q.ctrl.irq_sel[1] & (tc_pulse | half_hit));
        ovr_clr  = clr_fire | (ctl_we & ~wr_ctrl.stream_en);
        fail_evt = st_q.ctrl.stream_en & stream_err;

        st_d         = st_q;
        st_d.af_pend = st_q.ctrl.auto_flush & half_hit;
        if (ctl_we) st_d.ctrl = wr_ctrl;
        st_d.irq = irq_set | (st_q.irq & ~irq_ack);

        if (ovr_clr) begin
            st_d.ovr       = 1'b0;
            st_d.fail_pend = 1'b0;
        end else begin
            if (conv_done & (st_q.fail_pend | wr_drop)) st_d.ovr = 1'b1;
            if (fail_evt)       st_d.fail_pend = 1'b1;
            else if (conv_done) st_d.fail_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq     = st_q.irq;
    assign overrun = st_q.ovr;

    logic unused_full;
    assign unused_full = fifo_full;
endmodule

// File: rtl/acq_fifo_ctrl_chk.sv
module acq_fifo_ctrl_chk #(
    parameter int DEPTH = 1024,
    parameter int CW    = 11,
    parameter int CLR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_we,
    input logic [CLR_W-1:0] clr_wdata,
    input logic             irq_ack,
    input logic             conv_done,
    input logic             pacer_tick,
    input logic             rd_en,
    input logic [CW-1:0]    fifo_count,
    input logic             irq,
    input logic             overrun,
    input logic             start_conv
);
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_ack |=> irq); // R6

    AST_CLR_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we && clr_wdata == '0 |=> !overrun); // R10

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we && clr_wdata == '0 |=> fifo_count == '0); // R11

    AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count == CW'(DEPTH) && conv_done && !rd_en && !clr_we
        |=> fifo_count == CW'(DEPTH)); // R8

    AST_START_PACED: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv |-> $past(pacer_tick)); // R12

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH)); // R2
endmodule

bind acq_fifo_ctrl acq_fifo_ctrl_chk #(.DEPTH(DEPTH), .CW(CW), .CLR_W(CLR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_we     (clr_we),
    .clr_wdata  (clr_wdata),
    .irq_ack    (irq_ack),
    .conv_done  (conv_done),
    .pacer_tick (pacer_tick),
    .rd_en      (rd_en),
    .fifo_count (fifo_count),
    .irq        (irq),
    .overrun    (overrun),
    .start_conv (start_conv)
);

// File: tb/test_acq_fifo_ctrl.sv
module test_acq_fifo_ctrl;
    localparam int DW    = 12;
    localparam int DEPTH = 1024;
    localparam int CW    = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 0, clr_we = 0, irq_ack = 0, conv_done = 0;
    logic pacer_tick = 0, tc_pulse = 0, ext_trig = 0, stream_err = 0, rd_en = 0;
    logic [6:0] ctl_wdata = '0;
    logic [7:0] clr_wdata = '0;
    logic [DW-1:0] conv_data = '0;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] fifo_count;
    logic fifo_empty, irq, trig_seen, overrun, start_conv;

    int n_run = 0, n_fail = 0;
    logic [DW-1:0] exp_q [$];

    always #2 clk = ~clk;

    acq_fifo_ctrl i_acq_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata), .irq_ack(irq_ack),
        .conv_done(conv_done), .conv_data(conv_data), .pacer_tick(pacer_tick),
        .tc_pulse(tc_pulse), .ext_trig(ext_trig), .stream_err(stream_err),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_count(fifo_count),
        .fifo_empty(fifo_empty), .irq(irq), .trig_seen(trig_seen),
        .overrun(overrun), .start_conv(start_conv)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // fields: int_pacer, trig_en, stream_en, pretrig_en, auto_flush, sel
    task automatic wctl(input logic ip, te, se, pe, af, input logic [1:0] sel);
        ctl_we = 1; ctl_wdata = {ip, te, se, pe, af, sel};
        step(); ctl_we = 0;
    endtask

    task automatic wclr(input logic [7:0] v);
        clr_we = 1; clr_wdata = v;
        step(); clr_we = 0;
        if (v == 0) exp_q.delete();
    endtask

    task automatic ack();
        irq_ack = 1; step(); irq_ack = 0;
    endtask

    // driver: offers a sample and records what the FIFO should keep
    task automatic conv(input logic [DW-1:0] d);
        if (exp_q.size() < DEPTH) exp_q.push_back(d);
        conv_done = 1; conv_data = d;
        step(); conv_done = 0;
    endtask

    // monitor: pops one sample and compares against the scoreboard
    task automatic pop(input string req);
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(req, int'(rd_data), int'(e));
        rd_en = 1; step(); rd_en = 0;
    endtask

    task automatic tick_check(input string req, input int exp);
        pacer_tick = 1; step(); pacer_tick = 0;
        check(req, int'(start_conv), exp);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // reset state (R1)
        check("R1 irq", int'(irq), 0);
        check("R1 overrun", int'(overrun), 0);
        check("R1 count", int'(fifo_count), 0);
        check("R1 empty", int'(fifo_empty), 1);
        check("R1 start", int'(start_conv), 0);
        check("R1 trig_seen", int'(trig_seen), 0);

        // R2 ordering, several patterns; select 01 so R4 is checked too
        wctl(0, 0, 0, 0, 0, 2'b01);
        conv(12'h000); conv(12'hFFF); conv(12'hA5A); conv(12'h123);
        check("R4 sel01 no irq", int'(irq), 0);
        check("R2 count", int'(fifo_count), 4);
        pop("R2"); pop("R2");
        conv(12'h5A5);
        pop("R2"); pop("R2"); pop("R2");
        check("R2 empty", int'(fifo_empty), 1);

        // R3 / R6
        wctl(0, 0, 0, 0, 0, 2'b00);
        conv(12'h011);
        check("R3 irq on conv", int'(irq), 1);
        repeat (3) step();
        check("R6 irq sticky", int'(irq), 1);
        ack();
        check("R6 irq acked", int'(irq), 0);
        irq_ack = 1; conv_done = 1; conv_data = 12'h022; exp_q.push_back(12'h022);
        step(); irq_ack = 0; conv_done = 0;
        check("R6 set beats ack", int'(irq), 1);
        ack();

        // R5 terminal count and half-full
        wclr(0);
        wctl(0, 0, 0, 0, 0, 2'b10);
        tc_pulse = 1; step(); tc_pulse = 0;
        check("R5 tc irq", int'(irq), 1);
        ack();
        for (int i = 0; i < DEPTH/2 - 1; i++) conv(DW'(i));
        check("R5 below half no irq", int'(irq), 0);
        conv(12'h777);
        check("R5 half irq", int'(irq), 1);
        check("R5 count 512", int'(fifo_count), DEPTH/2);
        ack();

        // R7 auto-flush
        wclr(0);
        wctl(0, 0, 0, 0, 1, 2'b11);
        for (int i = 0; i < DEPTH/2; i++) conv(DW'(i));
        check("R7 irq at half", int'(irq), 1);
        step();
        check("R7 flushed", int'(fifo_count), 0);
        exp_q.delete();
        ack();

        // R8 / R9 full FIFO
        wctl(0, 0, 0, 0, 0, 2'b01);
        wclr(0);
        for (int i = 0; i < DEPTH; i++) conv(DW'(i * 7 + 3));
        check("R8 full count", int'(fifo_count), DEPTH);
        check("R9 no ovr yet", int'(overrun), 0);
        conv(12'hBAD);
        check("R9 ovr on full", int'(overrun), 1);
        check("R8 count kept", int'(fifo_count), DEPTH);
        wclr(8'h05);
        check("R10 nonzero clr ovr", int'(overrun), 1);
        check("R10 nonzero clr count", int'(fifo_count), DEPTH);
        for (int i = 0; i < DEPTH; i++) pop("R8 contents");
        check("R8 drained", int'(fifo_empty), 1);
        wclr(0);
        check("R10 clr clears ovr", int'(overrun), 0);

        // R9 handshake failure, R10 stream disable
        wctl(0, 0, 1, 0, 0, 2'b01);
        stream_err = 1; step(); stream_err = 0;
        check("R9 pending only", int'(overrun), 0);
        conv(12'h101);
        check("R9 ovr after fail", int'(overrun), 1);
        wctl(0, 0, 0, 0, 0, 2'b01);
        check("R10 stream off clears", int'(overrun), 0);
        stream_err = 1; step(); stream_err = 0;
        conv(12'h102);
        check("R9 fail ignored when off", int'(overrun), 0);

        // R11 clear with simultaneous write
        clr_we = 1; clr_wdata = 0; conv_done = 1; conv_data = 12'h3C3;
        step(); clr_we = 0; conv_done = 0; exp_q.delete();
        check("R11 write dropped", int'(fifo_count), 0);

        // R12 triggered block
        wctl(1, 1, 0, 0, 0, 2'b01);
        tick_check("R12 held before trig", 0);
        ext_trig = 1; repeat (4) step();
        tick_check("R12 run after trig", 1);
        tick_check("R12 still running", 1);
        tc_pulse = 1; step(); tc_pulse = 0;
        tick_check("R12 stopped at tc", 0);
        repeat (3) step();
        tick_check("R12 level not re-arm", 0);
        ext_trig = 0; repeat (4) step();

        // R13 external pacing
        wctl(0, 1, 0, 1, 0, 2'b01);
        ext_trig = 1; repeat (4) step();
        check("R13 trig ignored", int'(trig_seen), 0);
        tick_check("R13 tick starts", 1);
        ext_trig = 0; repeat (4) step();

        // R14 pre-trigger
        wctl(1, 1, 0, 1, 0, 2'b01);
        tick_check("R14 runs pre-trig", 1);
        check("R14 not seen yet", int'(trig_seen), 0);
        ext_trig = 1; repeat (4) step();
        check("R14 trig seen", int'(trig_seen), 1);
        tick_check("R14 runs after", 1);
        wclr(0);
        check("R14 seen cleared", int'(trig_seen), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule